// File: doc/BRIEF.md
# Decoded Johnson Decade Sequencer

A synchronous sequencer built around a five-stage twisted-ring register. Each rising clock edge moves it one step through ten states, and a one-hot bank of ten registered lines shows which state it is in. A carry line is high for the first half of the cycle and low for the second half. Several instances can be chained by clocking the next one from this carry.

Two control options change the sequence. The short-cycle option takes a modulus from 2 to 9 and wraps the ring back to state 0 early, on a clock edge. The halt option picks one line, and when that line goes high the ring freezes until the next reset. A hold input pauses the count at any time. A synchronous reset returns the ring to state 0 and overrides every other input.

Top module: `jdec_seq`

## Requirements
- R1: With reset, hold, short-cycle and halt all inactive, each rising edge moves the active line from index k to index (k+1) mod 10. The new line appears at the outputs on the edge that makes the move.
- R2: Outside reset, exactly one bit of `line_o` is high. Bit k stands for state k.
- R3: A rising edge with `rst` high sets `line_o` to 10'b0000000001 and `carry_o` to 1. This takes priority over `hold_i`, `short_en` and `halt_en`.
- R4: A rising edge with `hold_i` high and `rst` low leaves `line_o` unchanged.
- R5: When `short_en` is low, `carry_o` is 1 while line 0 to 4 is active and 0 while line 5 to 9 is active. This gives a 1:1 square wave with a period of ten clocks.
- R6: When `short_en` is high and 2 <= `short_n` <= 9, the edge that leaves line `short_n`-1 activates line 0, so each cycle uses only lines 0 to `short_n`-1. For any other `short_n` value, the full ten-state sequence of R1 runs.
- R7: When `short_en` is high and 2 <= `short_n` <= 4, `carry_o` equals `line_o[0]`. For a valid `short_n` of 5 to 9, `carry_o` follows the rule of R5.
- R8: When `halt_en` is high and `halt_line` < 10, `line_o` stays frozen once bit `halt_line` is active, until an edge with `rst` high. A `halt_line` value of 10 to 15 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to state 0 |
| hold_i | input | 1 | Active-high pause; holds the present state |
| short_en | input | 1 | Enables the early-wrap modulus |
| short_n | input | 4 | Modulus used when `short_en` is high (2 to 9 valid) |
| halt_en | input | 1 | Enables halt on a selected line |
| halt_line | input | 4 | Index of the line that freezes the sequence |
| line_o | output | 10 | Registered one-hot state lines |
| carry_o | output | 1 | Registered carry, one cycle per sequence |

## Verification
The checker assumes that `short_en`, `short_n`, `halt_en` and `halt_line` change only while `rst` is high. Its carry and wrap properties compare the outputs with the mode that produced them, so a mode change in the middle of a sequence would break them. The bench follows this: every scenario task sets the mode first and then issues a reset before counting. `hold_i` may toggle freely, and the bench also raises it during a reset to exercise the reset priority of R3.

// File: rtl/jdec_pkg.sv
package jdec_pkg;
  // Action chosen for the twisted ring on the coming edge.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_WRAP = 2'd2
  } ring_act_e;
endpackage

// File: rtl/jdec_ring.sv
module jdec_ring
  import jdec_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  ring_act_e         act,
  output logic [STAGES-1:0] ring_q,
  output logic [STAGES-1:0] ring_nxt
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] shifted;

  // Twisted shift. Stage 2 only keeps a one from stage 1 when a
  // neighbour backs it up, which clears isolated ones so that an illegal
  // pattern falls back into the ten-state loop.
  always_comb begin
    shifted    = {ring_q[TOP-1:0], ~ring_q[TOP]};
    shifted[2] = ring_q[1] & (ring_q[0] | ring_q[2]);
  end

  always_comb begin
    unique case (act)
      ACT_STEP: ring_nxt = shifted;
      ACT_WRAP: ring_nxt = '0;
      default:  ring_nxt = ring_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ring_q <= '0;
    else     ring_q <= ring_nxt;
  end
endmodule

// File: rtl/jdec_decode.sv
module jdec_decode #(
  parameter int STAGES = 5,
  localparam int OUTS  = 2 * STAGES
) (
  input  logic [STAGES-1:0] ring,
  output logic [OUTS-1:0]   lines
);
  // Each line looks at one adjacent pair of stages only.
  for (genvar k = 0; k < OUTS; k++) begin : g_line
    if (k == 0) begin : g_zero
      assign lines[k] = ~ring[STAGES-1] & ~ring[0];
    end else if (k < STAGES) begin : g_fill
      assign lines[k] = ring[k-1] & ~ring[k];
    end else if (k == STAGES) begin : g_full
      assign lines[k] = ring[STAGES-1] & ring[0];
    end else begin : g_drain
      assign lines[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
    end
  end
endmodule

// File: rtl/jdec_ctrl.sv
module jdec_ctrl
  import jdec_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int OUTS  = 2 * STAGES,
  localparam int SEL_W = $clog2(OUTS)
) (
  input  logic [OUTS-1:0]  line_cur,
  input  logic             hold_i,
  input  logic             short_en,
  input  logic [SEL_W-1:0] short_n,
  input  logic             halt_en,
  input  logic [SEL_W-1:0] halt_line,
  output ring_act_e        act,
  output logic             carry_from_zero
);
  localparam logic [SEL_W-1:0] N_MIN  = SEL_W'(2);
  localparam logic [SEL_W-1:0] N_MAX  = SEL_W'(OUTS - 1);
  localparam logic [SEL_W-1:0] N_HALF = SEL_W'(STAGES);
  localparam logic [SEL_W-1:0] ONE    = SEL_W'(1);
  localparam logic [SEL_W-1:0] LAST   = SEL_W'(OUTS - 1);

  logic             n_ok;
  logic             sel_ok;
  logic [SEL_W-1:0] n_last;
  logic             at_wrap;
  logic             at_halt;

  assign n_ok    = short_en && (short_n >= N_MIN) && (short_n <= N_MAX);
  assign sel_ok  = halt_en && (halt_line <= LAST);
  assign n_last  = short_n - ONE;
  assign at_wrap = n_ok && line_cur[n_last];
  assign at_halt = sel_ok && line_cur[halt_line];

  always_comb begin
    if (hold_i || at_halt) act = ACT_HOLD;
    else if (at_wrap)      act = ACT_WRAP;
    else                   act = ACT_STEP;
  end

  assign carry_from_zero = n_ok && (short_n < N_HALF);
endmodule

// File: rtl/jdec_seq.sv
module jdec_seq
  import jdec_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int OUTS  = 2 * STAGES,
  localparam int SEL_W = $clog2(OUTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  input  logic             short_en,
  input  logic [SEL_W-1:0] short_n,
  input  logic             halt_en,
  input  logic [SEL_W-1:0] halt_line,
  output logic [OUTS-1:0]  line_o,
  output logic             carry_o
);
  ring_act_e         act;
  logic              carry_from_zero;
  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_nxt;
  logic [OUTS-1:0]   line_nxt;

  jdec_ring #(.STAGES(STAGES)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .ring_q   (ring_q),
    .ring_nxt (ring_nxt)
  );

  jdec_decode #(.STAGES(STAGES)) u_dec (
    .ring  (ring_nxt),
    .lines (line_nxt)
  );

  // The controller sees the registered lines, which always decode ring_q.
  jdec_ctrl #(.STAGES(STAGES)) u_ctrl (
    .line_cur        (line_o),
    .hold_i          (hold_i),
    .short_en        (short_en),
    .short_n         (short_n),
    .halt_en         (halt_en),
    .halt_line       (halt_line),
    .act             (act),
    .carry_from_zero (carry_from_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o  <= OUTS'(1);
      carry_o <= 1'b1;
    end else begin
      line_o  <= line_nxt;
      carry_o <= carry_from_zero ? line_nxt[0] : ~ring_nxt[STAGES-1];
    end
  end
endmodule

// File: rtl/jdec_seq_chk.sv
module jdec_seq_chk #(
  parameter int STAGES = 5,
  localparam int OUTS  = 2 * STAGES,
  localparam int SEL_W = $clog2(OUTS)
) (
  input logic             clk,
  input logic             rst,
  input logic             hold_i,
  input logic             short_en,
  input logic [SEL_W-1:0] short_n,
  input logic             halt_en,
  input logic [SEL_W-1:0] halt_line,
  input logic [OUTS-1:0]  line_o,
  input logic             carry_o
);
  localparam logic [SEL_W-1:0] ONE = SEL_W'(1);
  localparam logic [SEL_W-1:0] TWO = SEL_W'(2);

  p_rotate_r1: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && !halt_en && !short_en) |=>
      line_o == {$past(line_o[OUTS-2:0]), $past(line_o[OUTS-1])});

  p_single_line_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(line_o) == 1);

  p_reset_state_r3: assert property (@(posedge clk)
    rst |=> (line_o == OUTS'(1)) && carry_o);

  p_hold_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(line_o));

  p_carry_half_r5: assert property (@(posedge clk) disable iff (rst)
    !short_en |-> carry_o == (|line_o[STAGES-1:0]));

  p_early_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (short_en && short_n >= TWO && short_n <= SEL_W'(OUTS-1) &&
     !hold_i && !halt_en && line_o[short_n - ONE]) |=> line_o[0]);

  p_short_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (short_en && short_n >= TWO && short_n < SEL_W'(STAGES)) |->
      carry_o == line_o[0]);

  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (halt_en && halt_line <= SEL_W'(OUTS-1) && line_o[halt_line]) |=>
      $stable(line_o));
endmodule

bind jdec_seq jdec_seq_chk #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hold_i    (hold_i),
  .short_en  (short_en),
  .short_n   (short_n),
  .halt_en   (halt_en),
  .halt_line (halt_line),
  .line_o    (line_o),
  .carry_o   (carry_o)
);

// File: tb/tb_jdec_seq.sv
module tb_jdec_seq;
  localparam int CLK_P = 10;
  localparam int OUTS  = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold_i = 1'b0;
  logic       short_en = 1'b0;
  logic [3:0] short_n = 4'd0;
  logic       halt_en = 1'b0;
  logic [3:0] halt_line = 4'd0;
  logic [OUTS-1:0] line_o;
  logic       carry_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  jdec_seq dut (
    .clk (clk), .rst (rst), .hold_i (hold_i),
    .short_en (short_en), .short_n (short_n),
    .halt_en (halt_en), .halt_line (halt_line),
    .line_o (line_o), .carry_o (carry_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_mode(input logic se, input int sn, input logic he, input int hl);
    short_en = se; short_n = 4'(sn); halt_en = he; halt_line = 4'(hl);
  endtask

  // R3: reset wins even with hold high.
  task automatic t_reset();
    set_mode(1'b0, 0, 1'b0, 0);
    edges(3);
    hold_i = 1'b1;
    pulse_reset();
    chk("R3 line after reset", 32'(line_o), 32'(1));
    chk("R3 carry after reset", 32'(carry_o), 32'(1));
    hold_i = 1'b0;
  endtask

  // R1, R2, R5: free-running ten-state loop.
  task automatic t_free_run();
    set_mode(1'b0, 0, 1'b0, 0);
    pulse_reset();
    for (int i = 1; i <= 22; i++) begin
      edges(1);
      chk("R1 free-run line", 32'(line_o), 32'(OUTS'(1) << (i % 10)));
      chk("R2 single line", 32'($countones(line_o)), 32'(1));
      chk("R5 carry half", 32'(carry_o), 32'((i % 10) < 5));
    end
  endtask

  // R4: hold freezes the sequence, then counting resumes.
  task automatic t_hold();
    set_mode(1'b0, 0, 1'b0, 0);
    pulse_reset();
    edges(3);
    hold_i = 1'b1;
    edges(4);
    chk("R4 held line", 32'(line_o), 32'(OUTS'(1) << 3));
    hold_i = 1'b0;
    edges(1);
    chk("R1 resume after hold", 32'(line_o), 32'(OUTS'(1) << 4));
  endtask

  // R6, R7: short cycle with modulus n (invalid n runs ten states).
  task automatic t_short(input int n);
    int m;
    m = (n >= 2 && n <= 9) ? n : 10;
    set_mode(1'b1, n, 1'b0, 0);
    pulse_reset();
    for (int i = 1; i <= 2 * m + 1; i++) begin
      edges(1);
      chk($sformatf("R6 short n=%0d line", n), 32'(line_o), 32'(OUTS'(1) << (i % m)));
      if (m < 5)
        chk($sformatf("R7 short n=%0d carry", n), 32'(carry_o), 32'((i % m) == 0));
      else
        chk($sformatf("R7 short n=%0d carry", n), 32'(carry_o), 32'((i % m) < 5));
    end
  endtask

  // R8: halt on a selected line until reset.
  task automatic t_halt(input int sel);
    set_mode(1'b0, 0, 1'b1, sel);
    pulse_reset();
    if (sel <= 9) begin
      edges(sel);
      chk($sformatf("R8 reach line %0d", sel), 32'(line_o), 32'(OUTS'(1) << sel));
      edges(5);
      chk($sformatf("R8 stay line %0d", sel), 32'(line_o), 32'(OUTS'(1) << sel));
      pulse_reset();
      chk("R8 reset restarts", 32'(line_o), 32'(1));
      if (sel != 0) begin
        edges(1);
        chk("R8 counts after restart", 32'(line_o), 32'(2));
      end
    end else begin
      edges(12);
      chk("R8 out-of-range select ignored", 32'(line_o), 32'(OUTS'(1) << 2));
    end
  endtask

  initial begin
    edges(2);
    rst = 1'b0;
    t_reset();
    t_free_run();
    t_hold();
    t_short(3);
    t_short(4);
    t_short(5);
    t_short(9);
    t_short(1);
    t_short(12);
    t_halt(6);
    t_halt(0);
    t_halt(9);
    t_halt(12);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule